// File: doc/BRIEF.md
# Terminal Transmit Handshake Sequencer

This block runs the transmit phase of a block-mode display terminal. While the terminal is receiving, it waits for the operator's transmit key. The key press must coincide with a pulse showing that an end-of-text (ETX) character is passing through the recirculating character memory. When both arrive together, the block raises request-to-send (RTS), empties its three-stage character chain and drops the receive steering level.

Once clear-to-send (CTS) comes back, the next timing-phase pulse fires a one-shot header load. Start-of-text (STX) goes into the output stage and a fixed address character goes into the middle stage. The transmit steering level follows on a later phase pulse. From then on, a character is taken from memory on each cursor-found strobe whenever the chain has room. Characters move toward the output stage and leave it on each interface-ready strobe.

Once the ETX itself has been taken into the chain, no more characters are taken and a timeout counter runs. The terminal returns to receive once the timeout has expired and the chain is empty.

The controller has five states:
- `ST_RECV`: receive mode.
- `ST_WAIT_CTS`: RTS is up and the block waits for CTS.
- `ST_HDR`: the header is loaded and pending.
- `ST_XMIT`: characters are taken from memory.
- `ST_DRAIN`: ETX has been taken and the timeout runs.

The transitions are:
- start (`ST_RECV`→`ST_WAIT_CTS`)
- enter-header (`ST_WAIT_CTS`→`ST_HDR`)
- enable-transmit (`ST_HDR`→`ST_XMIT`)
- etx-taken (`ST_XMIT`→`ST_DRAIN`)
- release (`ST_DRAIN`→`ST_RECV`)

Top module: `xmit_seq`

## Requirements
- R1: After the synchronous active-high reset, `rx_steer` is 1, and `rts`, `tx_steer` and `out_valid` are 0.
- R2: In receive mode, a cycle in which `etx_seen` and `xmit_key` are both 1 starts transmit. From the next cycle, `rts` is 1, `rx_steer` is 0 and all chain stages are empty.
- R3: While waiting for CTS, the first cycle with `cts` and `phase_tick` both 1 loads the header. After that edge, `out_char` shows STX (7'h02), the middle stage holds `HDR_ADDR`, and `tx_steer` is still 0.
- R4: After the header load, a later cycle with `phase_tick` and the enable condition sets `tx_steer` to 1 from the next cycle. The enable condition is `cts` when `CTS_ONLY`=1, and `cts`&`rts` when `CTS_ONLY`=0. `out_valid` is 1 only while `tx_steer` is 1.
- R5: In `ST_XMIT`, `cursor_hit` takes `mem_char` into stage 1 only if at least one stage is empty or stage 3 is leaving in the same cycle. Otherwise the strobe is ignored.
- R6: Characters leave the chain in the order they entered: STX, then the address, then the message. Stage 3 leaves on a cycle with `out_valid` and `if_ready` both 1. Otherwise `out_char` and `out_valid` hold.
- R7: When the character taken is ETX (7'h03), no more characters are taken and the timeout counter starts from zero on the next cycle.
- R8: `rts` and `tx_steer` stay 1 until the timeout counter has counted `TMO_CYCLES` cycles in `ST_DRAIN` and all stages are empty. The next edge returns to receive. If ETX is taken at edge E and the last character leaves at edge P, `rx_steer` rises at edge max(E+`TMO_CYCLES`+1, P+1).
- R9: In receive mode, `xmit_key` without `etx_seen`, or `etx_seen` without `xmit_key`, leaves `rts` at 0 and `rx_steer` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etx_seen | input | 1 | Pulse: ETX is present in the memory entry register |
| xmit_key | input | 1 | Transmit key pressed |
| cts | input | 1 | Clear-to-send from the modem |
| phase_tick | input | 1 | Timing-phase pulse |
| cursor_hit | input | 1 | Cursor-found strobe from memory |
| mem_char | input | 7 | Character read from memory |
| if_ready | input | 1 | Interface ready to take the output character |
| rts | output | 1 | Request-to-send |
| tx_steer | output | 1 | Transmit steering level |
| rx_steer | output | 1 | Receive steering level |
| out_char | output | 7 | Character in the output stage |
| out_valid | output | 1 | Output character valid (transmit only) |

## Verification
The assertions check the following on every cycle:
- RTS rises only after a coincident ETX pulse and key press.
- Transmit steering rises only after a phase pulse seen with CTS.
- Transmit steering never appears without RTS.
- RTS falls only after the timeout has expired and the chain is empty.
- A waiting output character holds still.
- The timeout counter steps by one while running.

Only the bench scenarios can show the rest:
- the exact character order on the output;
- that strobes are refused when the chain is full and ignored after ETX;
- the exact edge on which receive returns, across message lengths and interface-ready and cursor-strobe rates.

// File: rtl/xmit_pkg.sv
package xmit_pkg;
    localparam int CHW = 7;
    localparam logic [CHW-1:0] CH_STX = 7'h02;
    localparam logic [CHW-1:0] CH_ETX = 7'h03;

    typedef enum logic [2:0] {
        ST_RECV,
        ST_WAIT_CTS,
        ST_HDR,
        ST_XMIT,
        ST_DRAIN
    } seq_state_t;
endpackage

// File: rtl/xmit_chain.sv
module xmit_chain
    import xmit_pkg::*;
#(
    parameter logic [CHW-1:0] HDR_ADDR = 7'h41
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           hdr_load,
    input  logic           take,
    input  logic [CHW-1:0] din,
    input  logic           pop_en,
    input  logic           if_ready,
    output logic           accept,
    output logic [CHW-1:0] dout,
    output logic           dout_v,
    output logic           empty
);
    localparam int NST = 3;

    logic [CHW-1:0] dat [NST];
    logic [NST-1:0] vld;
    logic [NST-1:0] free;
    logic [NST-1:0] mv;
    logic           pop;

    assign pop = vld[NST-1] & pop_en & if_ready;

    // Free slots ripple back from the output stage so a whole chain can shift at once
    always_comb begin
        free[NST-1] = ~vld[NST-1] | pop;
        for (int i = NST - 2; i >= 0; i--) begin
            mv[i]   = vld[i] & free[i+1];
            free[i] = ~vld[i] | mv[i];
        end
        mv[NST-1] = pop;
    end

    assign accept = take & free[0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
        end else if (hdr_load) begin
            vld[2] <= 1'b1;
            dat[2] <= CH_STX;
            vld[1] <= 1'b1;
            dat[1] <= HDR_ADDR;
            vld[0] <= 1'b0;
        end else begin
            for (int i = NST - 1; i >= 1; i--) begin
                if (mv[i-1]) begin
                    vld[i] <= 1'b1;
                    dat[i] <= dat[i-1];
                end else if (mv[i]) begin
                    vld[i] <= 1'b0;
                end
            end
            if (accept) begin
                vld[0] <= 1'b1;
                dat[0] <= din;
            end else if (mv[0]) begin
                vld[0] <= 1'b0;
            end
        end
    end

    assign dout   = dat[NST-1];
    assign dout_v = vld[NST-1];
    assign empty  = ~|vld;

    // R6: an output character that is not taken stays put
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (vld[NST-1] && !pop && !clr && !hdr_load) |=> (vld[NST-1] && $stable(dat[NST-1])));
endmodule

// File: rtl/xmit_tmo.sv
module xmit_tmo #(
    parameter int TMO_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(TMO_CYCLES + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TMO_CYCLES);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);

    // R7: once started, the counter advances by one each cycle until it expires
    assert_tmo_step_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !done) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/xmit_seq.sv
module xmit_seq
    import xmit_pkg::*;
#(
    parameter logic [6:0] HDR_ADDR   = 7'h41,
    parameter int         TMO_CYCLES = 16,
    parameter bit         CTS_ONLY   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       etx_seen,
    input  logic       xmit_key,
    input  logic       cts,
    input  logic       phase_tick,
    input  logic       cursor_hit,
    input  logic [6:0] mem_char,
    input  logic       if_ready,
    output logic       rts,
    output logic       tx_steer,
    output logic       rx_steer,
    output logic [6:0] out_char,
    output logic       out_valid
);
    seq_state_t state, state_nx;

    logic tx_gate;
    logic start_go;
    logic hdr_go;
    logic take;
    logic accept;
    logic etx_in;
    logic chain_empty;
    logic chain_v;
    logic tmo_done;

    generate
        if (CTS_ONLY) begin : g_gate_cts
            assign tx_gate = cts;
        end else begin : g_gate_cts_rts
            assign tx_gate = cts & rts;
        end
    endgenerate

    assign start_go = (state == ST_RECV) && etx_seen && xmit_key;
    assign hdr_go   = (state == ST_WAIT_CTS) && cts && phase_tick;
    assign take     = (state == ST_XMIT) && cursor_hit;
    assign etx_in   = accept && (mem_char == CH_ETX);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RECV;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RECV:     if (start_go) state_nx = ST_WAIT_CTS;
            ST_WAIT_CTS: if (hdr_go) state_nx = ST_HDR;
            ST_HDR:      if (phase_tick && tx_gate) state_nx = ST_XMIT;
            ST_XMIT:     if (etx_in) state_nx = ST_DRAIN;
            ST_DRAIN:    if (tmo_done && chain_empty) state_nx = ST_RECV;
            default:     state_nx = ST_RECV;
        endcase
    end

    always_comb begin
        rts      = 1'b1;
        rx_steer = 1'b0;
        tx_steer = 1'b0;
        unique case (state)
            ST_RECV: begin
                rts      = 1'b0;
                rx_steer = 1'b1;
            end
            ST_WAIT_CTS, ST_HDR: ;
            ST_XMIT, ST_DRAIN: tx_steer = 1'b1;
            default: ;
        endcase
    end

    xmit_chain #(.HDR_ADDR(HDR_ADDR)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_go),
        .hdr_load (hdr_go),
        .take     (take),
        .din      (mem_char),
        .pop_en   (tx_steer),
        .if_ready (if_ready),
        .accept   (accept),
        .dout     (out_char),
        .dout_v   (chain_v),
        .empty    (chain_empty)
    );

    xmit_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_DRAIN),
        .done (tmo_done)
    );

    assign out_valid = chain_v & tx_steer;

    // R2: RTS rises only on a coincident ETX pulse and key press
    assert_start_cond_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rts) |-> $past(etx_seen && xmit_key));

    // R4: transmit steering rises only after a phase pulse seen with CTS
    assert_tx_after_cts_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_steer) |-> $past(cts && phase_tick));

    // R8: transmit steering never appears without RTS
    assert_tx_with_rts_R8: assert property (@(posedge clk) disable iff (rst)
        tx_steer |-> rts);

    // R8: RTS falls only after the timeout has expired and the chain has drained
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rts) |-> $past(tmo_done && chain_empty));
endmodule

// File: tb/sim_xmit_seq.sv
module sim_xmit_seq;
    localparam int         TMO  = 6;
    localparam logic [6:0] ADDR = 7'h41;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       etx_seen = 1'b0, xmit_key = 1'b0, cts = 1'b0, phase_tick = 1'b0;
    logic       cursor_hit = 1'b0, if_ready = 1'b0;
    logic [6:0] mem_char = '0;
    logic       rts, tx_steer, rx_steer, out_valid;
    logic [6:0] out_char;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done_f = 1'b0;

    always #10 clk = ~clk;

    xmit_seq #(.HDR_ADDR(ADDR), .TMO_CYCLES(TMO), .CTS_ONLY(1'b1)) u0 (
        .clk(clk), .rst(rst), .etx_seen(etx_seen), .xmit_key(xmit_key), .cts(cts),
        .phase_tick(phase_tick), .cursor_hit(cursor_hit), .mem_char(mem_char),
        .if_ready(if_ready), .rts(rts), .tx_steer(tx_steer), .rx_steer(rx_steer),
        .out_char(out_char), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_f) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_msg(input int len, input int stall, input int cur_every);
        logic [6:0] seq [0:15];
        int idx = 0, k = 0, occ = 2, edge_n = 0, e_etx = -1, p_last = 0, rise = -1;
        bit etx_taken = 1'b0, held_ok = 1'b1, ir, ch, pop, acc;

        seq[0] = 7'h02;
        seq[1] = ADDR;
        for (int i = 0; i < len; i++) seq[2+i] = 7'(7'h40 + i);
        seq[len+2] = 7'h03;

        // R2: start
        @(negedge clk); etx_seen = 1; xmit_key = 1;
        @(negedge clk); etx_seen = 0; xmit_key = 0;
        chk(rts == 1 && rx_steer == 0 && tx_steer == 0, "R2 start", {rts, rx_steer, tx_steer}, 3'b100);

        // R3: phase pulses without CTS do nothing
        for (int i = 0; i < 2; i++) begin
            phase_tick = 1;
            @(negedge clk);
        end
        phase_tick = 0;
        chk(tx_steer == 0 && out_valid == 0, "R4 no tx without cts", tx_steer, 0);

        // R3: header load
        cts = 1; phase_tick = 1;
        @(negedge clk); phase_tick = 0;
        chk(out_char == 7'h02 && tx_steer == 0, "R3 header STX", out_char, 7'h02);

        @(negedge clk);
        chk(tx_steer == 0, "R4 tx waits for phase", tx_steer, 0);

        phase_tick = 1;
        @(negedge clk); phase_tick = 0;
        chk(tx_steer == 1 && out_valid == 1, "R4 tx enable", {tx_steer, out_valid}, 2'b11);

        for (int c = 0; c < 300 && rise < 0; c++) begin
            ir = (c % stall) == 0;
            ch = (c % cur_every) == 0;
            if_ready   = ir;
            cursor_hit = ch;
            mem_char   = etx_taken ? 7'h55 : (idx < len ? 7'(7'h40 + idx) : 7'h03);
            pop = out_valid && ir;
            acc = ch && !etx_taken && (occ < 3 || pop);
            if (pop) begin
                chk(k <= len + 2 && out_char == seq[k], "R6 order", out_char, seq[k]);
                k++;
            end
            @(posedge clk);
            edge_n++;
            occ = occ - int'(pop) + int'(acc);
            if (pop) p_last = edge_n;
            if (acc) begin
                if (idx == len) begin
                    etx_taken = 1'b1;
                    e_etx = edge_n;
                end
                idx++;
            end
            @(negedge clk);
            if (rx_steer) rise = edge_n;
            else if (!(rts && tx_steer)) held_ok = 1'b0;
        end
        if_ready = 0; cursor_hit = 0; cts = 0;

        chk(k == len + 3, "R5 char count", k, len + 3);
        chk(held_ok, "R8 rts/tx held", held_ok, 1);
        chk(rise == ((e_etx + TMO + 1 > p_last + 1) ? e_etx + TMO + 1 : p_last + 1),
            "R7 release edge", rise,
            (e_etx + TMO + 1 > p_last + 1) ? e_etx + TMO + 1 : p_last + 1);
        chk(rts == 0 && tx_steer == 0 && out_valid == 0, "R8 back to receive",
            {rts, tx_steer, out_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(rx_steer == 1 && rts == 0 && tx_steer == 0 && out_valid == 0, "R1 reset",
            {rx_steer, rts, tx_steer, out_valid}, 4'b1000);

        xmit_key = 1;
        @(negedge clk); xmit_key = 0;
        @(negedge clk);
        chk(rts == 0 && rx_steer == 1, "R9 key alone", rts, 0);

        etx_seen = 1;
        @(negedge clk); etx_seen = 0;
        @(negedge clk);
        chk(rts == 0 && rx_steer == 1, "R9 etx alone", rts, 0);

        for (int len = 0; len <= 5; len++)
            for (int st = 1; st <= 3; st++)
                for (int ce = 1; ce <= 2; ce++)
                    run_msg(len, st, ce);

        done_f = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule